// File: doc/BRIEF.md
# Instruction Fetch Alignment Checker

This block decides, for each instruction fetch, whether the fetch proceeds or raises an instruction-address-misaligned exception. It keeps the compressed-instruction enable bit and derives the alignment rule from it. With compressed instructions enabled, fetches only need 16-bit alignment, so no fetch can fault. With them disabled, fetches need 32-bit alignment, and any fetch address with bit 1 set faults. Bit 0 of a fetch address is never examined.

Each instruction that retires hands the block the address to fetch next, with a kind code. The block arms on that target and checks the fetch of that address. Misalignment is never reported when a jump, a trap return or an enable-bit write retires. It is reported only when the resulting target is fetched. That target is checked against the rule in force at fetch time. After a fault the block stays idle until the redirect to the trap handler retires.

The state machine has four states:
- ARMED waits for the fetch of the recorded target.
- BUSY: a fetched instruction is in flight.
- FAULT is the one-cycle exception report.
- TRAPWAIT waits for the handler redirect.

Transitions:
- ARMED→BUSY on a good fetch.
- ARMED→FAULT on a misaligned fetch.
- ARMED→ARMED on a retire, which replaces the target.
- BUSY→ARMED on any retire.
- FAULT→TRAPWAIT always.
- TRAPWAIT→ARMED on a handler-entry retire.

Top module: `fetch_align_chk`

## Requirements
- R1: After reset, compressed instructions are enabled, the block is armed on target address RESET_PC (default 0), and fetch_ok and exc_valid are low.
- R2: While compressed instructions are enabled, a fetch of the armed target never raises an exception, whatever bit 1 of the address is. fetch_ok pulses high for one cycle in the cycle after the fetch request.
- R3: While compressed instructions are disabled, a fetch of the armed target with address bit 1 set raises an exception in the following cycle. In that cycle exc_valid=1, exc_cause=0, exc_tval equals the fetch address and fetch_ok=0.
- R4: Address bit 0 never causes a fault. Under the 32-bit rule, an address ending in binary 01 is accepted and one ending in 11 faults.
- R5: A write to the compressed-enable bit (cen_wr_en=1, value cen_wr_data) never raises an exception by itself. The new value governs every fetch request from the next cycle on.
- R6: A retire of any kind (ret_kind 0 sequential, 1 jump/branch, 2 trap return, 3 handler entry) never causes an exception by itself, even with a misaligned ret_next_pc. The target is checked when it is fetched.
- R7: In ARMED, a fetch request whose address differs from the armed target is ignored: no fetch_ok, no exception. A retire in ARMED replaces the target, and a fetch in that same cycle is ignored.
- R8: After an exception, fetch requests and retires of kinds 0 to 2 are ignored until a retire of kind 3 arms the block on its ret_next_pc.
- R9: While an accepted instruction is in flight (BUSY), fetch requests are ignored until the next retire arms the block.
- R10: exc_valid is never high in two consecutive cycles and is never high together with fetch_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cen_wr_en | input | 1 | Write strobe for the compressed-enable bit |
| cen_wr_data | input | 1 | Value written to the compressed-enable bit |
| ret_valid | input | 1 | Retire strobe |
| ret_kind | input | 2 | 0 sequential, 1 jump/branch, 2 trap return, 3 handler entry |
| ret_next_pc | input | XLEN | Address to fetch next |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | XLEN | Fetch request address |
| fetch_ok | output | 1 | One-cycle pulse: fetch accepted |
| exc_valid | output | 1 | One-cycle pulse: misaligned fetch |
| exc_cause | output | CAUSE_W | Cause code, 0 while exc_valid is high |
| exc_tval | output | XLEN | Faulting fetch address |

## Verification
The hardest situation to reach from the ports is a misaligned target that slipped through under the 16-bit rule and only faults because the enable bit was cleared by the very instruction that retired just before the fetch. Reaching it needs a write, a retire of a target with bit 1 set, and a matching fetch, in the right order. Directed sequences build this order and its variants: a jump, a trap return, and a write in the same cycle as the retire. Random stimulus from a fixed seed then mixes retires, fetches biased toward the armed target, rare enable toggles and low-bit patterns. A bench model of the four states predicts every cycle.

// File: rtl/fac_pkg.sv
package fac_pkg;

    typedef enum logic [1:0] {
        KIND_SEQ     = 2'd0,
        KIND_JUMP    = 2'd1,
        KIND_TRET    = 2'd2,
        KIND_HANDLER = 2'd3
    } ret_kind_e;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_BUSY     = 2'd1,
        ST_FAULT    = 2'd2,
        ST_TRAPWAIT = 2'd3
    } fac_state_e;

    localparam int unsigned CAUSE_FETCH_MISALIGNED = 0;

endpackage

// File: rtl/fac_ialign.sv
module fac_ialign (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic addr_bit1,
    output logic cen,
    output logic misaligned
);

    logic cen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q <= 1'b1;
        end else if (wr_en) begin
            cen_q <= wr_data;
        end
    end

    // 16-bit rule when enabled, 32-bit rule otherwise; bit 0 never inspected
    always_comb begin
        misaligned = !cen_q && addr_bit1;
    end

    assign cen = cen_q;

    a_r2_enabled_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        cen_q |-> !misaligned);

    a_r4_bit1_clear_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_bit1 |-> !misaligned);

endmodule

// File: rtl/fac_target.sv
module fac_target #(
    parameter int unsigned XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] load_val,
    input  logic            clear,
    input  logic [XLEN-1:0] fetch_addr,
    output logic            match
);

    logic [XLEN-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= RESET_PC;
        end else if (load) begin
            tgt_q <= load_val;
        end else if (clear) begin
            tgt_q <= '0;
        end
    end

    always_comb begin
        match = (fetch_addr == tgt_q);
    end

endmodule

// File: rtl/fac_fsm.sv
module fac_fsm
    import fac_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [XLEN-1:0]    fetch_addr,
    input  logic               match,
    input  logic               misaligned,
    input  logic               ret_valid,
    input  logic [1:0]         ret_kind,
    output logic               load_tgt,
    output logic               clear_tgt,
    output logic               fetch_ok,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);

    fac_state_e state_q, state_d;
    ret_kind_e  kind;
    logic       take_fetch;
    logic       fetch_ok_q;
    logic [XLEN-1:0] tval_q;

    assign kind = ret_kind_e'(ret_kind);

    // next-state logic: a retire in ARMED wins over a same-cycle fetch
    always_comb begin
        state_d    = state_q;
        load_tgt   = 1'b0;
        clear_tgt  = 1'b0;
        take_fetch = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (ret_valid) begin
                    load_tgt = 1'b1;
                end else if (fetch_req && match) begin
                    take_fetch = 1'b1;
                    state_d    = misaligned ? ST_FAULT : ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (ret_valid) begin
                    load_tgt = 1'b1;
                    state_d  = ST_ARMED;
                end
            end
            ST_FAULT: begin
                clear_tgt = 1'b1;
                state_d   = ST_TRAPWAIT;
            end
            ST_TRAPWAIT: begin
                if (ret_valid && kind == KIND_HANDLER) begin
                    load_tgt = 1'b1;
                    state_d  = ST_ARMED;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ok_q <= 1'b0;
            tval_q     <= '0;
        end else begin
            fetch_ok_q <= take_fetch && !misaligned;
            if (take_fetch && misaligned) begin
                tval_q <= fetch_addr;
            end
        end
    end

    always_comb begin
        fetch_ok  = fetch_ok_q;
        exc_valid = (state_q == ST_FAULT);
        exc_cause = exc_valid ? CAUSE_W'(CAUSE_FETCH_MISALIGNED) : '0;
        exc_tval  = tval_q;
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_valid && fetch_ok));

    a_r6_fault_only_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !(fetch_req && match && !ret_valid)) |=> !exc_valid);

    a_r8_hold_until_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAPWAIT && !(ret_valid && kind == KIND_HANDLER))
        |=> (state_q == ST_TRAPWAIT && !fetch_ok));

    a_r9_busy_ignores_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> (!fetch_ok && !exc_valid));

endmodule

// File: rtl/fetch_align_chk.sv
module fetch_align_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned CAUSE_W  = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cen_wr_en,
    input  logic               cen_wr_data,
    input  logic               ret_valid,
    input  logic [1:0]         ret_kind,
    input  logic [XLEN-1:0]    ret_next_pc,
    input  logic               fetch_req,
    input  logic [XLEN-1:0]    fetch_addr,
    output logic               fetch_ok,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);

    logic cen;
    logic misaligned;
    logic match;
    logic load_tgt;
    logic clear_tgt;

    fac_ialign u_ialign (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cen_wr_en),
        .wr_data    (cen_wr_data),
        .addr_bit1  (fetch_addr[1]),
        .cen        (cen),
        .misaligned (misaligned)
    );

    fac_target #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_tgt),
        .load_val   (ret_next_pc),
        .clear      (clear_tgt),
        .fetch_addr (fetch_addr),
        .match      (match)
    );

    fac_fsm #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .match      (match),
        .misaligned (misaligned),
        .ret_valid  (ret_valid),
        .ret_kind   (ret_kind),
        .load_tgt   (load_tgt),
        .clear_tgt  (clear_tgt),
        .fetch_ok   (fetch_ok),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause),
        .exc_tval   (exc_tval)
    );

    a_r3_fault_needs_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && cen) |=> !exc_valid);

endmodule

// File: tb/sim_fetch_align_chk.sv
`timescale 1ns/1ps
module sim_fetch_align_chk;

    localparam int XLEN = 32;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cen_wr_en = 1'b0, cen_wr_data = 1'b0;
    logic            ret_valid = 1'b0;
    logic [1:0]      ret_kind = 2'd0;
    logic [XLEN-1:0] ret_next_pc = '0;
    logic            fetch_req = 1'b0;
    logic [XLEN-1:0] fetch_addr = '0;
    logic            fetch_ok, exc_valid;
    logic [CW-1:0]   exc_cause;
    logic [XLEN-1:0] exc_tval;

    always #2.5 clk = ~clk;

    fetch_align_chk #(.XLEN(XLEN), .CAUSE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cen_wr_en(cen_wr_en), .cen_wr_data(cen_wr_data),
        .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_next_pc(ret_next_pc),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ok(fetch_ok), .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
    );

    // bench model: 0 armed, 1 busy, 2 fault, 3 trapwait
    int              m_st;
    logic            m_cen;
    logic [XLEN-1:0] m_tgt, m_tval;
    int              n_cmp = 0, n_bad = 0;
    string           tag = "R1";
    bit              done = 0;

    function automatic bit is_misaligned(logic cen, logic [XLEN-1:0] a);
        return !cen && a[1];
    endfunction

    task automatic check1(string t, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // one cycle: apply inputs after negedge, predict, compare at following negedge
    task automatic cyc(bit fr, logic [XLEN-1:0] fa, bit rv, logic [1:0] rk,
                       logic [XLEN-1:0] rpc, bit we, bit wd);
        bit e_ok;
        fetch_req = fr; fetch_addr = fa; ret_valid = rv; ret_kind = rk;
        ret_next_pc = rpc; cen_wr_en = we; cen_wr_data = wd;
        e_ok = 0;
        case (m_st)
            0: begin
                if (rv) m_tgt = rpc;
                else if (fr && fa == m_tgt) begin
                    if (is_misaligned(m_cen, fa)) begin m_st = 2; m_tval = fa; end
                    else begin m_st = 1; e_ok = 1; end
                end
            end
            1: if (rv) begin m_tgt = rpc; m_st = 0; end
            2: begin m_st = 3; m_tgt = '0; end
            default: if (rv && rk == 2'd3) begin m_tgt = rpc; m_st = 0; end
        endcase
        if (we) m_cen = wd;
        @(negedge clk);
        check1(tag, "fetch_ok", {31'd0, fetch_ok}, {31'd0, e_ok});
        check1(tag, "exc_valid", {31'd0, exc_valid}, {31'd0, (m_st == 2)});
        if (m_st == 2) begin
            check1(tag, "exc_cause", {28'd0, exc_cause}, 32'd0);
            check1(tag, "exc_tval", exc_tval, m_tval);
        end
    endtask

    task automatic idle();        cyc(0, '0, 0, 0, '0, 0, 0); endtask
    task automatic fetch(logic [XLEN-1:0] a); cyc(1, a, 0, 0, '0, 0, 0); endtask
    task automatic retire(logic [1:0] k, logic [XLEN-1:0] pc); cyc(0, '0, 1, k, pc, 0, 0); endtask
    task automatic wr_cen(bit v); cyc(0, '0, 0, 0, '0, 1, v); endtask

    initial begin
        m_st = 0; m_cen = 1; m_tgt = '0; m_tval = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1"; check1(tag, "reset fetch_ok", {31'd0, fetch_ok}, 32'd0);
        check1(tag, "reset exc_valid", {31'd0, exc_valid}, 32'd0);
        idle();
        tag = "R7"; fetch(32'h4);                      // not the armed target
        tag = "R1"; fetch(32'h0);                      // armed on reset PC
        tag = "R9"; fetch(32'h0); fetch(32'h8);        // busy: ignored
        tag = "R2"; retire(2'd1, 32'h102); fetch(32'h102);
        // R5: write and retire in the same cycle, then fetch of misaligned next PC
        tag = "R5"; cyc(0, '0, 1, 2'd0, 32'h106, 1, 0);
        tag = "R3"; fetch(32'h106); idle();
        tag = "R8"; fetch(32'h106); retire(2'd0, 32'h40); retire(2'd2, 32'h44); fetch(32'h40);
        retire(2'd3, 32'h200); fetch(32'h200);
        tag = "R4"; retire(2'd2, 32'h301); fetch(32'h301);
        retire(2'd1, 32'h303); fetch(32'h303); idle(); retire(2'd3, 32'h400); fetch(32'h400);
        tag = "R6"; retire(2'd2, 32'h402); idle(); fetch(32'h402); idle();
        retire(2'd3, 32'h500);
        tag = "R7"; cyc(1, 32'h500, 1, 2'd1, 32'h600, 0, 0); fetch(32'h500); fetch(32'h600);
        tag = "R5"; wr_cen(1); retire(2'd0, 32'h60a); fetch(32'h60a);
        tag = "R10"; retire(2'd1, 32'h700); wr_cen(0); fetch(32'h700);
        // random phase
        tag = "R2/R3";
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [XLEN-1:0] a, p;
            r = int'($urandom_range(0, 99));
            p = {$urandom_range(0, 255), 2'b00} | XLEN'($urandom_range(0, 3));
            a = ($urandom_range(0, 3) != 0) ? m_tgt : (m_tgt ^ XLEN'($urandom_range(1, 3)));
            cyc(r < 55, a, (r >= 40 && r < 75), 2'($urandom_range(0, 3)), p,
                r >= 94, 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule